// File: doc/BRIEF.md
# Minimum-Mode Bus Cycle Controller

This block runs the external bus cycles of a 16-bit processor with a 20-bit physical address space. Its external bus multiplexes address and data. An internal requester asks for a single read or write. Each request carries a physical address, a byte-or-word size, a memory-or-I/O select and write data. The controller turns that request into one or two four-state bus cycles. It produces the address latch strobe, the active-low read and write strobes, the memory/I/O select, the transceiver direction and enable, and the active-low upper-byte enable.

Slow devices stretch a cycle by holding `ready` low. Each low sample adds one wait state. A word at an odd address cannot move in one transfer. The controller splits it into two byte transfers and steers each byte to the lane that the upper-byte enable and address bit 0 select. On a read it reassembles the two bytes into one word. Another bus master can take the bus through `hold`. The controller completes the transfer in progress, raises `hlda` and releases every bus output. It gives the bus back one clock after `hold` is removed.

A cycle has four states. T1 drives the address and pulses `ale`. T2 asserts the strobe and, for a read, turns the bus around. T3 samples `ready`, and a wait state Tw repeats while `ready` is low. T4 removes the strobes. The requester raises `req_valid` while the controller is idle. It keeps `req_valid` and the request fields stable until `done` pulses, then drops `req_valid`.

Top module: `bus_cycle_ctl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the outputs are: `rd_n`, `wr_n`, `den_n` and `bhe_n` = 1; `ale`, `done`, `hlda` and `ad_oe` = 0; `bus_oe` = 1.
- R2: T1 lasts one clock, with `ale`=1 and `ad_oe`=1. `ad_out` carries address bits 15..0 and `a_hi` carries bits 19..16, while `rd_n`, `wr_n` and `den_n` stay 1. `m_io` (1 = memory, 0 = I/O) and `dt_r` (1 = write, 0 = read) take their values in T1 and hold them through T4.
- R3: On a read, `rd_n`=0 and `den_n`=0 from T2 through the last T3/Tw, and `ad_oe`=0 from T2 onward. `ad_in` is sampled on the clock edge that ends the last T3/Tw.
- R4: On a write, `wr_n`=0 and `den_n`=0 from T2 through the last T3/Tw. Write data is on `ad_out` with `ad_oe`=1 from T2 through T4. A byte write puts its byte on both lanes.
- R5: Each clock edge that ends T3 or Tw with `ready`=0 adds one Tw cycle, and the strobes stay asserted through it.
- R6: Lane selection in T1 is as follows. A byte at an even address has A0 (`ad_out[0]`)=0 and `bhe_n`=1, and its data is on bits 7..0. A byte at an odd address has A0=1 and `bhe_n`=0, and its data is on bits 15..8. A word at an even address has A0=0 and `bhe_n`=0 and moves in one cycle. A byte read returns the byte in `rd_data[7:0]` with `rd_data[15:8]`=0.
- R7: A word at odd address a takes two cycles. The first is at a, with `bhe_n`=0, and the low byte on bits 15..8. The second is at a+1 modulo 2^20, with `bhe_n`=1, and the high byte on bits 7..0. A read returns {high byte, low byte}.
- R8: `done` is high for exactly one clock, in T4 of the final transfer of a request. `rd_data` holds the read result from that cycle until the next read's `done`. Writes leave it unchanged.
- R9: `hold` is honoured when the controller is idle and at the end of any T4, including between the two halves of a split word. While held, `hlda`=1, `bus_oe`=0 and `rd_n`=`wr_n`=1, and no cycle starts (`ale`=0).
- R10: `hlda` falls on the first clock edge that samples `hold`=0. The controller then spends one idle cycle before it starts the next T1, which is the second half if a split word was interrupted.
- R11: A request seen with `req_valid`=1 in an idle cycle with `hold`=0 starts T1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present, held until `done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr | input | 20 | Physical byte address |
| req_wdata | input | 16 | Write data (byte in bits 7..0) |
| rd_data | output | 16 | Read result |
| done | output | 1 | One-cycle completion pulse |
| ad_out | output | 16 | Multiplexed address/data, driven value |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 16 | Multiplexed address/data, received value |
| a_hi | output | 4 | Upper address in T1, zero status otherwise |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | 1 = memory, 0 = I/O |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Transceiver enable, active low |
| bhe_n | output | 1 | Upper-byte enable, active low |
| bus_oe | output | 1 | Drive enable for all bus outputs |
| ready | input | 1 | Device ready, active high |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |

## Verification
The hardest condition to reach is a `hold` that arrives between the two halves of a split odd-address word. The controller must park in the held state with the low byte already captured. After the bus comes back, it must resume with the second half and still assemble the correct word. The stimulus starts an odd-address word read and raises `hold` during T2 of the first half, so that it is sampled at that half's T4. It keeps `hold` high for three cycles and then releases it. A cycle-by-cycle model in the bench checks every strobe and lane in each cycle through the hold and the resume. A separate run of the model covers the 20-bit wrap of an odd word at the top address.

// File: rtl/bus_cycle_ctl.sv
module bus_cycle_ctl #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic          req_mem,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] a_hi,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          m_io,
  output logic          dt_r,
  output logic          den_n,
  output logic          bhe_n,
  output logic          bus_oe,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda
);
  localparam int BW = DW / 2;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4, S_HELD} st_t;

  st_t           st;
  logic [AW-1:0] cur_addr;
  logic          cur_write, cur_word, cur_mem;
  logic [DW-1:0] cur_wdata;
  logic          second;
  logic [BW-1:0] low_byte;

  logic          split, part_last, part_bhe_n, strobe, active;
  logic [AW-1:0] part_addr;
  logic [BW-1:0] byte_out, lane_in;
  logic [DW-1:0] wr_lanes;

  assign split      = cur_word & cur_addr[0];
  assign part_last  = ~split | second;
  assign part_addr  = second ? cur_addr + AW'(1) : cur_addr;
  assign part_bhe_n = cur_word ? (split & second) : ~cur_addr[0];
  assign byte_out   = (split & second) ? cur_wdata[DW-1:BW] : cur_wdata[BW-1:0];
  assign wr_lanes   = (cur_word & ~split) ? cur_wdata : {byte_out, byte_out};
  assign lane_in    = part_addr[0] ? ad_in[DW-1:BW] : ad_in[BW-1:0];

  assign strobe = (st == S_T2) || (st == S_T3) || (st == S_TW);
  assign active = strobe || (st == S_T1) || (st == S_T4);

  assign ale    = (st == S_T1);
  assign rd_n   = ~(strobe & ~cur_write);
  assign wr_n   = ~(strobe & cur_write);
  assign den_n  = ~strobe;
  assign ad_oe  = (st == S_T1) || (cur_write && (strobe || st == S_T4));
  assign ad_out = (st == S_T1) ? part_addr[DW-1:0] : wr_lanes;
  assign a_hi   = (st == S_T1) ? part_addr[AW-1:DW] : '0;
  assign m_io   = cur_mem;
  assign dt_r   = cur_write;
  assign bhe_n  = active ? part_bhe_n : 1'b1;
  assign hlda   = (st == S_HELD);
  assign bus_oe = ~hlda;
  assign done   = (st == S_T4) && part_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cur_addr  <= '0;
      cur_write <= 1'b0;
      cur_word  <= 1'b0;
      cur_mem   <= 1'b0;
      cur_wdata <= '0;
      second    <= 1'b0;
      low_byte  <= '0;
      rd_data   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (hold) st <= S_HELD;
          else if (second) st <= S_T1;
          else if (req_valid) begin
            cur_addr  <= req_addr;
            cur_write <= req_write;
            cur_word  <= req_word;
            cur_mem   <= req_mem;
            cur_wdata <= req_wdata;
            st        <= S_T1;
          end
        end
        S_T1: st <= S_T2;
        S_T2: st <= S_T3;
        S_T3, S_TW: begin
          if (ready) begin
            st <= S_T4;
            if (!cur_write) begin
              if (cur_word && !split) rd_data <= ad_in;
              else if (split && !second) low_byte <= lane_in;
              else if (split) rd_data <= {lane_in, low_byte};
              else rd_data <= {{BW{1'b0}}, lane_in};
            end
          end else begin
            st <= S_TW;
          end
        end
        S_T4: begin
          second <= ~part_last;
          if (hold) st <= S_HELD;
          else if (!part_last) st <= S_T1;
          else st <= S_IDLE;
        end
        S_HELD: if (!hold) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  a_r3_den_with_strobe: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !den_n);
  a_r2_ale_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  a_r2_ale_quiet_strobes: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n && ad_oe));
  a_r2_dir_read: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !dt_r);
  a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> dt_r);
  a_r5_rd_stretch: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !ready) |=> !rd_n);
  a_r5_wr_stretch: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !ready) |=> !wr_n);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_n && wr_n && !ale));
  a_r9_held_quiet: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (rd_n && wr_n && !ale && !bus_oe));
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    !hold |=> !hlda);
  a_r7_second_half_even: assert property (@(posedge clk) disable iff (rst)
    (ale && second) |-> (!ad_out[0] && bhe_n));
endmodule

// File: tb/tb_bus_cycle_ctl.sv
module tb_bus_cycle_ctl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, req_valid, req_write, req_word, req_mem;
  logic [19:0] req_addr;
  logic [15:0] req_wdata, rd_data, ad_out, ad_in;
  logic        done, ad_oe, ale, rd_n, wr_n, m_io, dt_r, den_n, bhe_n, bus_oe;
  logic [3:0]  a_hi;
  logic        ready, hold, hlda;
  logic [19:0] lat;

  int checks = 0;
  int errors = 0;
  logic [15:0] kept;

  bus_cycle_ctl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_mem(req_mem), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r), .den_n(den_n), .bhe_n(bhe_n),
    .bus_oe(bus_oe), .ready(ready), .hold(hold), .hlda(hlda)
  );

  function automatic logic [7:0] mem_b(logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h3} ^ 8'hA5;
  endfunction

  always @(posedge clk) if (ale) lat <= {a_hi, ad_out};
  assign ad_in = {mem_b({lat[19:1], 1'b1}), mem_b({lat[19:1], 1'b0})};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(string nm, bit wr, bit word, bit mem, logic [19:0] a,
                      logic [15:0] wd, int waits, bit hold_mid);
    int nparts;
    logic [15:0] rexp;
    nparts = (word && a[0]) ? 2 : 1;
    rexp = word ? {mem_b(a + 20'd1), mem_b(a)} : {8'h00, mem_b(a)};
    req_write = wr; req_word = word; req_mem = mem; req_addr = a;
    req_wdata = wd; req_valid = 1'b1;
    for (int p = 0; p < nparts; p++) begin
      logic [19:0] pa;
      logic        pb;
      logic [15:0] lanes;
      bit          last;
      pa = (p == 1) ? a + 20'd1 : a;
      pb = word ? (nparts == 2 && p == 1) : ~a[0];
      lanes = (word && nparts == 1) ? wd :
              (p == 1 ? {wd[15:8], wd[15:8]} : {wd[7:0], wd[7:0]});
      last = (p == nparts - 1);
      @(negedge clk);
      chk({nm, " R2/R11 T1 ale,rd_n,wr_n,den_n"}, {ale, rd_n, wr_n, den_n}, 4'b1111);
      chk({nm, " R2 T1 address"}, {a_hi, ad_out, ad_oe}, {pa, 1'b1});
      chk({nm, " R2 T1 m_io,dt_r"}, {m_io, dt_r}, {mem, wr});
      chk({nm, " R6/R7 T1 bhe_n"}, bhe_n, pb);
      chk({nm, " R8 no done in T1"}, done, 1'b0);
      @(negedge clk);
      chk({nm, " R3/R4 T2 strobes"}, {ale, rd_n, wr_n, den_n}, {1'b0, wr, ~wr, 1'b0});
      chk({nm, " R3/R4 T2 ad_oe"}, ad_oe, wr);
      if (wr) chk({nm, " R4/R6 T2 write lanes"}, ad_out, lanes);
      chk({nm, " R2 T2 bhe_n,m_io,dt_r"}, {bhe_n, m_io, dt_r}, {pb, mem, wr});
      if (hold_mid && p == 0) hold = 1'b1;
      for (int w = 0; w <= waits; w++) begin
        @(negedge clk);
        chk({nm, " R5 T3/Tw strobes"}, {ale, rd_n, wr_n, den_n}, {1'b0, wr, ~wr, 1'b0});
        chk({nm, " R8 no done in T3/Tw"}, {done, hlda}, 2'b00);
        ready = (w == waits);
      end
      @(negedge clk);
      ready = 1'b1;
      chk({nm, " R3 T4 strobes off"}, {ale, rd_n, wr_n, den_n}, 4'b0111);
      chk({nm, " R8 done in T4"}, done, last);
      chk({nm, " R2 T4 m_io,dt_r held"}, {m_io, dt_r}, {mem, wr});
      if (wr) chk({nm, " R4 T4 data held"}, {ad_oe, ad_out}, {1'b1, lanes});
      if (last && !wr) chk({nm, " R6/R7 read data"}, rd_data, rexp);
      if (last) req_valid = 1'b0;
      if (p == 0 && nparts == 2 && hold_mid) begin
        for (int h = 0; h < 3; h++) begin
          @(negedge clk);
          chk({nm, " R9 held between halves"}, {hlda, bus_oe, rd_n, wr_n, ale}, 5'b10110);
          if (h == 2) hold = 1'b0;
        end
        @(negedge clk);
        chk({nm, " R10 released, idle"}, {hlda, bus_oe, ale}, 3'b010);
      end
    end
    @(negedge clk);
    chk({nm, " R8 idle after done"}, {done, ale, rd_n, wr_n}, 4'b0011);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_mem = 1'b0; req_addr = '0; req_wdata = '0; ready = 1'b1; hold = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {rd_n, wr_n, den_n, bhe_n}, 4'b1111);
    chk("R1 reset ale,done,hlda,ad_oe,bus_oe", {ale, done, hlda, ad_oe, bus_oe}, 5'b00001);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle after reset", {ale, done, hlda, rd_n, wr_n}, 5'b00011);

    xfer("even byte read", 1'b0, 1'b0, 1'b1, 20'h12344, 16'h0000, 0, 1'b0);
    xfer("odd byte io read", 1'b0, 1'b0, 1'b0, 20'h00A71, 16'h0000, 2, 1'b0);
    xfer("even word read", 1'b0, 1'b1, 1'b1, 20'h3C0F6, 16'h0000, 1, 1'b0);
    kept = {mem_b(20'h3C0F7), mem_b(20'h3C0F6)};
    xfer("even byte write", 1'b1, 1'b0, 1'b1, 20'h01230, 16'h775A, 0, 1'b0);
    xfer("odd byte io write", 1'b1, 1'b0, 1'b0, 20'h45677, 16'h00C3, 1, 1'b0);
    xfer("even word write", 1'b1, 1'b1, 1'b1, 20'hABCDE, 16'hBEEF, 0, 1'b0);
    chk("R8 writes keep rd_data", rd_data, kept);
    xfer("odd word read", 1'b0, 1'b1, 1'b1, 20'h7F3A5, 16'h0000, 0, 1'b0);
    xfer("odd word write", 1'b1, 1'b1, 1'b1, 20'h10001, 16'h1234, 1, 1'b0);
    xfer("odd word wrap read R7", 1'b0, 1'b1, 1'b1, 20'hFFFFF, 16'h0000, 0, 1'b0);
    xfer("split with hold", 1'b0, 1'b1, 1'b0, 20'h2468B, 16'h0000, 1, 1'b1);

    hold = 1'b1;
    req_write = 1'b0; req_word = 1'b1; req_mem = 1'b1; req_addr = 20'h0F0F1;
    req_wdata = '0; req_valid = 1'b1;
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk("R9 idle hold, no cycle started", {hlda, bus_oe, ale, rd_n, wr_n}, 5'b10011);
    end
    hold = 1'b0;
    @(negedge clk);
    chk("R10 hlda drops after hold", {hlda, bus_oe, ale}, 3'b010);
    xfer("R11 pending request after hold", 1'b0, 1'b1, 1'b1, 20'h0F0F1, 16'h0000, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule